// File: doc/BRIEF.md
# Programmable LFSR Pattern Source for Logic Self-Test

This block produces an N-bit test pattern every enabled clock cycle for a logic self-test setup. A single state register is stepped by one of four rules. The rule is picked at seed-load time:

- a shift register with the XOR tree outside the chain (feedback into stage 0);
- a shift register with XOR gates between the stages (stage N-1 fed back into each tapped stage);
- a complete variant of either form, which also visits the all-zero state;
- a plain binary up-counter for exhaustive testing.

The middle coefficients h_1..h_{N-1} of the characteristic polynomial come in as a vector, and h_0 = h_N = 1 are implied.

A seed load captures four things: the seed, the coefficient vector, the topology bit and the mode. The pattern then advances once per cycle while `en` is high. The block raises a one-cycle flag when the pattern comes back to the loaded seed, which marks the end of a period. A plain-LFSR run that starts from all zeros cannot leave that state. The block holds there and reports it on a separate flag.

Top module: `lfsr_tpg`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `pattern`, `wrap` and `lockup` to 0 on that edge. It also selects counter mode.
- R2: A cycle with `load` high sets `pattern` to `seed` at the next edge and clears `wrap`. The same edge captures `taps`, `topo` and `mode`.
- R3: A cycle with `en` low and `load` low leaves `pattern` unchanged and `wrap` at 0.
- R4: With `topo`=0 and `mode`=0, each step shifts bit i-1 into bit i. Bit 0 receives the XOR of bit N-1 and of every bit i-1 for which `taps[i-1]` (coefficient h_i) is 1.
- R5: With `topo`=1 and `mode`=0, each step moves bit N-1 into bit 0. Each bit i≥1 receives bit i-1, XORed with bit N-1 when `taps[i-1]` is 1.
- R6: With N=4 and f(x)=1+x+x^4 (`taps`=3'b001), the period is 15 from any nonzero seed in both topologies.
- R7: With N=4, f(x)=1+x^2+x^4 (`taps`=3'b010), `topo`=1 and seed 4'b0001, the pattern repeats after 6 steps.
- R8: With `mode`=1 (complete), the NOR of bits 0..N-2 is XORed into the feedback. In either topology and with a primitive polynomial, the all-zero state is visited and the period is 2^N.
- R9: With `mode`=2 or 3 (counter), each step adds 1 modulo 2^N.
- R10: `wrap` is 1 in exactly those cycles whose pattern was reached by a step and equals the loaded seed.
- R11: With `mode`=0 and an all-zero pattern, `lockup` is 1, the pattern stays 0 and `wrap` stays 0.
- R12: Changes on `taps`, `topo` or `mode` between loads have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| load | input | 1 | Load seed and capture configuration |
| seed | input | N | Start state |
| taps | input | N-1 | Coefficients h_1..h_{N-1}; bit i-1 holds h_i |
| topo | input | 1 | 0: external XOR, 1: XOR between stages |
| mode | input | 2 | 0: LFSR, 1: complete LFSR, 2/3: counter |
| pattern | output | N | Current test pattern |
| wrap | output | 1 | Pattern has returned to the seed |
| lockup | output | 1 | Plain LFSR stuck in the all-zero state |

## Verification
The bench builds two copies of the block, one with N=4 and one with N=8. Both are driven by the same stimulus.

The N=4 copy makes the small-polynomial periods of 15, 6 and 16 observable in a few dozen cycles, and it makes the all-zero lockup easy to reach. The N=8 copy checks that a primitive degree-8 polynomial gives 255 steps, or 256 steps in complete mode, and that the counter wraps at 256.

The bench compares both copies every cycle against a bench-side model. Enable is random, and the coefficient input changes between loads.

// File: rtl/lfsr_tpg.sv
module lfsr_tpg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [N-1:0] seed,
  input  logic [N-2:0] taps,
  input  logic         topo,
  input  logic [1:0]   mode,
  output logic [N-1:0] pattern,
  output logic         wrap,
  output logic         lockup
);
  localparam logic [1:0] M_LFSR = 2'd0;
  localparam logic [1:0] M_FULL = 2'd1;
  localparam logic [1:0] M_CNT  = 2'd2;

  logic [N-1:0] st, seed_q, nxt;
  logic [N-2:0] taps_q;
  logic         topo_q;
  logic [1:0]   mode_q;
  logic         zfill, fb;

  assign zfill   = (mode_q == M_FULL) && (st[N-2:0] == '0);
  assign lockup  = (mode_q == M_LFSR) && (st == '0);
  assign pattern = st;

  always_comb begin
    fb  = st[N-1] ^ zfill;
    nxt = '0;
    if (mode_q[1]) begin
      nxt = st + 1'b1;
    end else if (!topo_q) begin
      for (int i = 1; i < N; i++) fb = fb ^ (taps_q[i-1] & st[i-1]);
      nxt = {st[N-2:0], fb};
    end else begin
      nxt[0] = fb;
      for (int i = 1; i < N; i++) nxt[i] = st[i-1] ^ (taps_q[i-1] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      seed_q <= '0;
      taps_q <= '0;
      topo_q <= 1'b0;
      mode_q <= M_CNT;
      wrap   <= 1'b0;
    end else if (load) begin
      st     <= seed;
      seed_q <= seed;
      taps_q <= taps;
      topo_q <= topo;
      mode_q <= mode;
      wrap   <= 1'b0;
    end else if (en && !lockup) begin
      st   <= nxt;
      wrap <= (nxt == seed_q);
    end else begin
      wrap <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pattern == '0 && !wrap && !lockup));

  // R2
  load_seed_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (pattern == $past(seed) && !wrap));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> ($stable(pattern) && !wrap));

  // R10
  wrap_at_seed_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (pattern == seed_q));

  // R11
  lockup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lockup && !load) |=> (pattern == '0 && !wrap));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && en && !load) |=> (pattern == $past(pattern) + 1'b1));
endmodule

// File: tb/lfsr_tpg_tb_top.sv
module lfsr_tpg_tb_top;
  logic       clk = 1'b0;
  logic       rst, en, load, topo;
  logic [7:0] seed;
  logic [6:0] taps;
  logic [1:0] mode;
  logic [3:0] pat4;
  logic [7:0] pat8;
  logic       wrap4, wrap8, lock4, lock8;
  int checks = 0;
  int errors = 0;
  int p4, p8, zero_seen;

  always #2 clk = ~clk;

  lfsr_tpg #(.N(4)) dut_i (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed[3:0]), .taps(taps[2:0]),
    .topo(topo), .mode(mode), .pattern(pat4), .wrap(wrap4), .lockup(lock4));

  lfsr_tpg #(.N(8)) dut8_i (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .taps(taps),
    .topo(topo), .mode(mode), .pattern(pat8), .wrap(wrap8), .lockup(lock8));

  function automatic logic [15:0] mdl(int w, logic [15:0] s, logic [15:0] t, logic tp, logic [1:0] m);
    logic [15:0] mask, n;
    logic z, f;
    mask = (16'd1 << w) - 16'd1;
    if (m[1]) return (s + 16'd1) & mask;
    z = (m == 2'd1) && ((s & (mask >> 1)) == 16'd0);
    f = s[w-1] ^ z;
    n = '0;
    if (!tp) begin
      for (int i = 1; i < w; i++) f = f ^ (t[i-1] & s[i-1]);
      n = ((s << 1) | {15'd0, f}) & mask;
    end else begin
      n[0] = f;
      for (int i = 1; i < w; i++) n[i] = s[i-1] ^ (t[i-1] & f);
    end
    return n;
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string step_tag(logic tp, logic [1:0] m);
    if (m[1]) return "R9";
    if (m == 2'd1) return "R8";
    return tp ? "R5" : "R4";
  endfunction

  task automatic run(logic [7:0] sd, logic [6:0] tp7, logic tp, logic [1:0] m, int cyc, bit rnd_en);
    logic [15:0] e4, e8, n4, n8;
    logic l4, l8;
    int st = 0;
    string tag;
    p4 = 0; p8 = 0; zero_seen = 0;
    tag = step_tag(tp, m);
    @(negedge clk);
    load = 1'b1; en = 1'b0; seed = sd; taps = tp7; topo = tp; mode = m;
    @(negedge clk);
    load = 1'b0;
    e4 = {12'd0, sd[3:0]}; e8 = {8'd0, sd};
    chk(pat4 == e4[3:0] && !wrap4, "R2 load n4", {12'd0, pat4}, e4);
    chk(pat8 == e8[7:0] && !wrap8, "R2 load n8", {8'd0, pat8}, e8);
    for (int c = 0; c < cyc; c++) begin
      en = rnd_en ? ($urandom_range(0, 3) != 0) : 1'b1;
      taps = 7'($urandom);
      topo = 1'($urandom);
      mode = 2'($urandom);
      @(negedge clk);
      l4 = (m == 2'd0) && (e4 == 0);
      l8 = (m == 2'd0) && (e8 == 0);
      if (en && !l4) begin
        n4 = mdl(4, e4, {9'd0, tp7}, tp, m);
        e4 = n4;
      end
      if (en && !l8) begin
        n8 = mdl(8, e8, {9'd0, tp7}, tp, m);
        e8 = n8;
      end
      if (en) st++;
      chk(pat4 == e4[3:0], en ? {tag, " R12 n4"} : "R3 hold n4", {12'd0, pat4}, e4);
      chk(pat8 == e8[7:0], en ? {tag, " R12 n8"} : "R3 hold n8", {8'd0, pat8}, e8);
      chk(wrap4 == (en && !l4 && e4[3:0] == sd[3:0]), "R10 wrap n4", {15'd0, wrap4}, 16'(en && !l4 && e4[3:0] == sd[3:0]));
      chk(wrap8 == (en && !l8 && e8[7:0] == sd), "R10 wrap n8", {15'd0, wrap8}, 16'(en && !l8 && e8[7:0] == sd));
      chk(lock4 == ((m == 2'd0) && e4 == 0), "R11 lockup n4", {15'd0, lock4}, 16'((m == 2'd0) && e4 == 0));
      if (wrap4 && p4 == 0) p4 = st;
      if (wrap8 && p8 == 0) p8 = st;
      if (pat4 == 4'd0) zero_seen = 1;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; en = 1'b0; load = 1'b0; seed = '0; taps = '0; topo = 1'b0; mode = 2'd0;
    repeat (3) @(negedge clk);
    chk(pat4 == 0 && !wrap4 && !lock4, "R1 reset n4", {12'd0, pat4}, 16'd0);
    chk(pat8 == 0 && !wrap8 && !lock8, "R1 reset n8", {8'd0, pat8}, 16'd0);
    rst = 1'b0;

    run(8'h01, 7'b0000001, 1'b0, 2'd0, 40, 1'b0);
    chk(p4 == 15, "R6 period standard", 16'(p4), 16'd15);
    run(8'h01, 7'b0000001, 1'b1, 2'd0, 40, 1'b0);
    chk(p4 == 15, "R6 period modular", 16'(p4), 16'd15);
    run(8'h01, 7'b0000010, 1'b1, 2'd0, 20, 1'b0);
    chk(p4 == 6, "R7 period 6", 16'(p4), 16'd6);
    run(8'h01, 7'b0000001, 1'b0, 2'd1, 40, 1'b0);
    chk(p4 == 16 && zero_seen == 1, "R8 complete standard", 16'(p4), 16'd16);
    run(8'h05, 7'b0000001, 1'b1, 2'd1, 40, 1'b0);
    chk(p4 == 16 && zero_seen == 1, "R8 complete modular", 16'(p4), 16'd16);
    run(8'hFE, 7'b0000000, 1'b0, 2'd2, 300, 1'b0);
    chk(p4 == 16, "R9 counter n4", 16'(p4), 16'd16);
    chk(p8 == 256, "R9 counter n8", 16'(p8), 16'd256);
    run(8'h01, 7'b0001110, 1'b1, 2'd0, 300, 1'b0);
    chk(p8 == 255, "R6 period n8 primitive", 16'(p8), 16'd255);
    run(8'h01, 7'b0001110, 1'b0, 2'd1, 300, 1'b0);
    chk(p8 == 256, "R8 complete n8", 16'(p8), 16'd256);
    run(8'h00, 7'b0000001, 1'b0, 2'd0, 10, 1'b0);
    chk(lock4 && lock8 && pat4 == 0, "R11 zero seed", {15'd0, lock4}, 16'd1);

    for (int k = 0; k < 30; k++)
      run(8'($urandom), 7'($urandom), 1'($urandom), 2'($urandom), 60, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule